// File: doc/BRIEF.md
# Control-Pin Mode Detector

This block watches a single control line after the device is switched on and settles, once per power-up, how the line will be used from then on. The line either carries a duty-cycle signal that scales the regulation reference, or serves as a single-wire command link. The block also notices when the line has been held low long enough to mean "switch off". It then issues a one-cycle shutdown pulse that sibling blocks use to return their registers to reset, so the stored reference goes back to full scale.

The line arrives already synchronised to the clock. A one-cycle tick every microsecond paces all timing. Switching on starts a detection window. The line must stay high for a short guard delay. After that, one low pulse that lasts longer than the detection time, and that falls inside the window, selects single-wire mode at once. Any other activity leaves the default duty-cycle mode in force. The choice holds until the next shutdown. The FSM has six states:
- `ST_OFF` (shut down)
- `ST_HOLD` (guard delay running)
- `ST_ARMED` (waiting for a low pulse inside the window)
- `ST_MEASURE` (timing a low pulse)
- `ST_DUTY` (duty-cycle mode locked)
- `ST_WIRE` (single-wire mode locked)

Transitions:
- `ST_OFF` goes to `ST_HOLD` when the line is high.
- `ST_HOLD` goes to `ST_DUTY` when the line drops early, or to `ST_ARMED` when the delay expires.
- `ST_ARMED` goes to `ST_MEASURE` when the line falls, or to `ST_DUTY` when the window ends.
- `ST_MEASURE` goes back to `ST_ARMED` when the line rises too soon, to `ST_WIRE` when the low time is exceeded, or to `ST_DUTY` when the window ends.
- Any other state goes to `ST_OFF` on a long low.

Top module: `ctrl_mode_detect`

## Requirements
- R1: After reset the enable flag, the mode flag (1 = single-wire, 0 = duty-cycle) and the shutdown pulse are all 0.
- R2: While shut down, a high line sets the enable flag on the next clock and restarts the window and delay tick counts from zero.
- R3: Single-wire mode is selected when a low pulse begins once DELAY_US ticks have passed since enabling and stays low for more than DETECT_US ticks before WINDOW_US ticks have passed since enabling.
- R4: The mode flag rises within one clock of the low pulse exceeding DETECT_US ticks, without waiting for the window to close.
- R5: If the window closes without a qualifying low pulse, including a low pulse still running when it closes, duty-cycle mode (mode flag 0) is kept.
- R6: Once a mode is chosen it stays unchanged, whatever the line does, until shutdown.
- R7: A low level seen while the guard delay is still running commits the block to duty-cycle mode.
- R8: When the line stays low for more than SHUT_US ticks while enabled, the enable flag clears and the shutdown output is high for exactly one clock. A low lasting no more than SHUT_US ticks has no effect.
- R9: A low pulse that is too short returns the block to waiting. A later low pulse inside the same window can still select single-wire mode.
- R10: The mode flag is 0 whenever the enable flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronised control-line level |
| tick_i | input | 1 | One-clock strobe each microsecond |
| enabled_o | output | 1 | Device enabled |
| mode_1w_o | output | 1 | 1 = single-wire command mode, 0 = duty-cycle mode |
| shutdown_o | output | 1 | One-clock pulse on shutdown; resets downstream registers |

## Verification
The block is driven through these line patterns:
- A steady high line, to check that the default mode survives the window.
- A clean qualifying low after the delay, to check immediate selection.
- A low that starts during the guard delay.
- A low that straddles the window end.
- A short low followed by a qualifying one, to check that a retry within the window is honoured.
- A fast duty-cycle waveform, which must never be mistaken for a command request.

Long lows just under and well over the shutdown limit separate "ignored" from "switch off". Line activity after each mode is locked shows that the choice cannot be undone short of shutdown.

// File: rtl/ctrl_mode_pkg.sv
package ctrl_mode_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HOLD    = 3'd1,
        ST_ARMED   = 3'd2,
        ST_MEASURE = 3'd3,
        ST_DUTY    = 3'd4,
        ST_WIRE    = 3'd5
    } cmd_state_e;
endpackage

// File: rtl/cmd_tick_counter.sv
module cmd_tick_counter #(
    parameter int unsigned MAXV = 1000,
    parameter int unsigned W    = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] LIMIT = W'(MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (tick_i && (cnt_o != LIMIT)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/cmd_mode_fsm.sv
module cmd_mode_fsm
    import ctrl_mode_pkg::*;
#(
    parameter int unsigned DELAY_US  = 100,
    parameter int unsigned DETECT_US = 260,
    parameter int unsigned WINDOW_US = 1000,
    parameter int unsigned SHUT_US   = 2500,
    parameter int unsigned WW        = 10,
    parameter int unsigned LW        = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic [WW-1:0] win_cnt_i,
    input  logic [LW-1:0] low_cnt_i,
    output logic          off_o,
    output logic          enabled_o,
    output logic          mode_1w_o,
    output logic          shutdown_o
);
    localparam logic [WW-1:0] DELAY_C  = WW'(DELAY_US);
    localparam logic [WW-1:0] WINDOW_C = WW'(WINDOW_US);
    localparam logic [LW-1:0] DETECT_C = LW'(DETECT_US);
    localparam logic [LW-1:0] SHUT_C   = LW'(SHUT_US);

    cmd_state_e st_q, st_d;
    logic       shut_hit, shut_q;
    logic       win_over;

    assign win_over = (win_cnt_i >= WINDOW_C);

    always_comb begin
        st_d     = st_q;
        shut_hit = 1'b0;
        if ((st_q != ST_OFF) && !line_i && (low_cnt_i > SHUT_C)) begin
            st_d     = ST_OFF;
            shut_hit = 1'b1;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (line_i) st_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (!line_i)                     st_d = ST_DUTY;
                    else if (win_cnt_i >= DELAY_C)   st_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (win_over)                    st_d = ST_DUTY;
                    else if (!line_i)                st_d = ST_MEASURE;
                end
                ST_MEASURE: begin
                    if (win_over)                    st_d = ST_DUTY;
                    else if (line_i)                 st_d = ST_ARMED;
                    else if (low_cnt_i > DETECT_C)   st_d = ST_WIRE;
                end
                ST_DUTY: st_d = ST_DUTY;
                ST_WIRE: st_d = ST_WIRE;
                default: st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            shut_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            shut_q <= shut_hit;
        end
    end

    always_comb begin
        off_o      = (st_q == ST_OFF);
        enabled_o  = (st_q != ST_OFF);
        mode_1w_o  = (st_q == ST_WIRE);
        shutdown_o = shut_q;
    end
endmodule

// File: rtl/ctrl_mode_detect.sv
module ctrl_mode_detect #(
    parameter int unsigned DELAY_US  = 100,
    parameter int unsigned DETECT_US = 260,
    parameter int unsigned WINDOW_US = 1000,
    parameter int unsigned SHUT_US   = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic tick_i,
    output logic enabled_o,
    output logic mode_1w_o,
    output logic shutdown_o
);
    localparam int unsigned WW = $clog2(WINDOW_US + 1);
    localparam int unsigned LW = $clog2(SHUT_US + 2);

    logic [WW-1:0] win_cnt;
    logic [LW-1:0] low_cnt;
    logic          off;

    cmd_tick_counter #(.MAXV(WINDOW_US), .W(WW)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (off),
        .tick_i(tick_i),
        .cnt_o (win_cnt)
    );

    cmd_tick_counter #(.MAXV(SHUT_US + 1), .W(LW)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (off | line_i),
        .tick_i(tick_i),
        .cnt_o (low_cnt)
    );

    cmd_mode_fsm #(
        .DELAY_US (DELAY_US),
        .DETECT_US(DETECT_US),
        .WINDOW_US(WINDOW_US),
        .SHUT_US  (SHUT_US),
        .WW       (WW),
        .LW       (LW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .win_cnt_i (win_cnt),
        .low_cnt_i (low_cnt),
        .off_o     (off),
        .enabled_o (enabled_o),
        .mode_1w_o (mode_1w_o),
        .shutdown_o(shutdown_o)
    );
endmodule

// File: rtl/ctrl_mode_checker.sv
module ctrl_mode_checker (
    input logic clk,
    input logic rst_n,
    input logic line_i,
    input logic enabled_o,
    input logic mode_1w_o,
    input logic shutdown_o
);
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> !shutdown_o);

    a_r8_pulse_disables: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !enabled_o);

    a_r8_pulse_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> $past(!line_i));

    a_r10_mode_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mode_1w_o |-> enabled_o);

    a_r2_high_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled_o && line_i) |=> enabled_o);

    a_r6_wire_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_o && mode_1w_o) |=> (mode_1w_o || shutdown_o));

    a_r3_wire_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_1w_o) |-> $past(!line_i));
endmodule

bind ctrl_mode_detect ctrl_mode_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_i),
    .enabled_o (enabled_o),
    .mode_1w_o (mode_1w_o),
    .shutdown_o(shutdown_o)
);

// File: tb/sim_ctrl_mode_detect.sv
`timescale 1ns/1ps
module sim_ctrl_mode_detect;
    localparam int DELAY  = 10;
    localparam int DETECT = 26;
    localparam int WINDOW = 100;
    localparam int SHUT   = 250;

    localparam int M_OFF = 0, M_HOLD = 1, M_ARM = 2, M_MEAS = 3, M_DUTY = 4, M_WIRE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_i = 1'b0;
    logic tick_i = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic enabled_o, mode_1w_o, shutdown_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_mode_detect #(
        .DELAY_US(DELAY), .DETECT_US(DETECT), .WINDOW_US(WINDOW), .SHUT_US(SHUT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .tick_i(tick_i),
        .enabled_o(enabled_o), .mode_1w_o(mode_1w_o), .shutdown_o(shutdown_o)
    );

    always @(negedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick_i <= (tdiv == 2'd3);
    end

    // Behavioural reference: absolute microsecond clock and event timestamps
    int m_st = M_OFF;
    bit m_shut = 1'b0;
    int us_now = 0, t_en = 0, t_low = 0;
    int el_win, el_low, ns;
    bit sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_OFF; m_shut = 1'b0; us_now = 0; t_en = 0; t_low = 0;
        end else begin
            el_win = us_now - t_en;
            el_low = us_now - t_low;
            ns = m_st;
            sh = 1'b0;
            if (m_st != M_OFF && !line_i && el_low > SHUT) begin
                ns = M_OFF; sh = 1'b1;
            end else if (m_st == M_OFF) begin
                if (line_i) ns = M_HOLD;
            end else if (m_st == M_HOLD) begin
                if (!line_i) ns = M_DUTY;
                else if (el_win >= DELAY) ns = M_ARM;
            end else if (m_st == M_ARM) begin
                if (el_win >= WINDOW) ns = M_DUTY;
                else if (!line_i) ns = M_MEAS;
            end else if (m_st == M_MEAS) begin
                if (el_win >= WINDOW) ns = M_DUTY;
                else if (line_i) ns = M_ARM;
                else if (el_low > DETECT) ns = M_WIRE;
            end
            if (tick_i) us_now = us_now + 1;
            if (m_st == M_OFF) t_en = us_now;
            if (m_st == M_OFF || line_i) t_low = us_now;
            m_st = ns;
            m_shut = sh;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("model enable (R2,R8)", enabled_o, logic'(m_st != M_OFF));
            chk("model mode (R3,R5,R6,R7,R9)", mode_1w_o, logic'(m_st == M_WIRE));
            chk("model pulse (R8)", shutdown_o, m_shut);
        end
    end

    task automatic wait_us(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic go_off();
        line_i = 1'b0;
        wait_us(300);
        chk("R10 off after long low", enabled_o, 1'b0);
        chk("R10 mode clear when off", mode_1w_o, 1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 enable at reset", enabled_o, 1'b0);
        chk("R1 mode at reset", mode_1w_o, 1'b0);
        chk("R1 pulse at reset", shutdown_o, 1'b0);
        rst_n = 1'b1;
        wait_us(3);

        // R2 + R5: steady high keeps default mode
        line_i = 1'b1;
        @(negedge clk);
        chk("R2 enable after high", enabled_o, 1'b1);
        wait_us(120);
        chk("R5 steady high stays duty", mode_1w_o, 1'b0);

        // R8: long low boundary then shutdown pulse
        line_i = 1'b0;
        wait_us(240);
        chk("R8 low below limit ignored", enabled_o, 1'b1);
        begin
            int pulses = 0;
            repeat (400) begin
                @(negedge clk);
                if (shutdown_o) pulses++;
            end
            chk("R8 exactly one pulse cycle", logic'(pulses == 1), 1'b1);
        end
        chk("R8 disabled after shutdown", enabled_o, 1'b0);
        chk("R10 mode zero when off", mode_1w_o, 1'b0);

        // R3 + R4 + R6: qualifying low then locked
        line_i = 1'b1;
        wait_us(20);
        line_i = 1'b0;
        wait_us(20);
        chk("R3 not yet past detect time", mode_1w_o, 1'b0);
        wait_us(10);
        chk("R4 single-wire before window end", mode_1w_o, 1'b1);
        line_i = 1'b1; wait_us(10);
        line_i = 1'b0; wait_us(100);
        line_i = 1'b1; wait_us(10);
        chk("R6 single-wire held", mode_1w_o, 1'b1);
        go_off();

        // R7: low during guard delay
        line_i = 1'b1; wait_us(5);
        line_i = 1'b0; wait_us(40);
        line_i = 1'b1; wait_us(10);
        chk("R7 early low gives duty", mode_1w_o, 1'b0);
        chk("R7 still enabled", enabled_o, 1'b1);
        wait_us(60);
        line_i = 1'b0; wait_us(40);
        line_i = 1'b1; wait_us(5);
        chk("R6 duty held", mode_1w_o, 1'b0);
        go_off();

        // R5: low still running when window closes
        line_i = 1'b1; wait_us(85);
        line_i = 1'b0; wait_us(40);
        line_i = 1'b1; wait_us(10);
        chk("R5 window closed during low", mode_1w_o, 1'b0);
        go_off();

        // R9: short low then qualifying low
        line_i = 1'b1; wait_us(20);
        line_i = 1'b0; wait_us(10);
        line_i = 1'b1; wait_us(5);
        chk("R9 short low no selection", mode_1w_o, 1'b0);
        line_i = 1'b0; wait_us(35);
        chk("R9 retry selects single-wire", mode_1w_o, 1'b1);
        go_off();

        // R5/R7: fast duty-cycle waveform
        line_i = 1'b1;
        for (int k = 0; k < 35; k++) begin
            wait_us(3);
            line_i = ~line_i;
        end
        line_i = 1'b1;
        wait_us(5);
        chk("R5 fast duty waveform stays duty", mode_1w_o, 1'b0);
        chk("R5 fast duty stays enabled", enabled_o, 1'b1);
        go_off();

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule